// File: doc/BRIEF.md
# Serial Link Training Sequencer

This block trains one serial lane at the level of whole ordered sets. It sits above the symbol coding layer. A receiver-present flag starts it. It then steps through two polling phases, four configuration phases and an idle handshake phase, and finally reports that the link is up. Every phase-to-phase step needs two things at once: enough qualifying ordered sets received, and enough ordered sets handed to the transmitter. In most phases the transmit count does not start on phase entry. It starts at the first qualifying received set.

Decoded ordered sets arrive one per cycle while the receive strobe is high. Each carries a kind, a link-number field and a lane-number field. The sequencer names the next set to transmit on a valid/ready pair. A programmable per-phase timeout drops the block back to receiver detection. This also discards every count and every captured number.

Top module: `lts_seq`

## Requirements
- R1: After reset the block waits in detection with `tx_valid_o` and `link_up_o` low. It leaves detection only when `rx_detected_i` is high.
- R2: In the first polling phase the block sends TS1 with both fields PAD. It moves on only after at least POLL_TX_MIN (default 1024) accepted transmissions, counted from phase entry, and 8 received TS1 or TS2 sets.
- R3: In the second polling phase the block sends TS2 with PAD fields. It needs 8 consecutive received TS2 and 16 accepted transmissions, counted from the first TS2 received in the phase. A non-TS2 set clears the receive run unless the run has already reached its target. It never clears the transmit count.
- R4: The first configuration phase sends TS1 with both fields PAD. It moves on after 2 consecutive received TS1 whose link field is not PAD, and it captures that link number.
- R5: The second configuration phase sends TS1 carrying the captured link and a PAD lane. It moves on after 2 consecutive TS1 with the captured link and a non-PAD lane.
- R6: The third configuration phase sends TS1 carrying the captured link and the local lane number LOCAL_LANE (default 0), which may differ from the received lane. It moves on after 2 consecutive TS2 with the captured link and a non-PAD lane, and it captures that lane.
- R7: The configuration-complete phase sends TS2 with the captured link and lane. It needs 8 consecutive TS2 whose link and lane both match the captured values, and 16 accepted transmissions counted from the first matching TS2.
- R8: The idle phase sends idle sets. It needs 8 consecutive received idle sets and 16 accepted transmissions counted from the first idle received. It then raises `link_up_o`, which stays high while idle sets keep being sent.
- R9: When a training phase lasts `timeout_lim_i` cycles (0 disables the timeout), the block returns to detection. All counts are cleared and the captured link and lane return to PAD.
- R10: A received set counts only in a cycle with `rx_valid_i` high. A transmission counts only in a cycle with both `tx_valid_o` and `tx_ready_i` high.
- R11: The kind code is 0 for TS1, 1 for TS2, 2 for idle and 3 for any other set. PAD is the field value 8'hF7, and a field equal to PAD does not count as a valid number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_detected_i | input | 1 | Far-end receiver present |
| timeout_lim_i | input | TMO_W | Per-phase timeout in cycles, 0 disables it |
| rx_valid_i | input | 1 | Received ordered set strobe |
| rx_type_i | input | 2 | Received set kind |
| rx_link_i | input | 8 | Received link-number field |
| rx_lane_i | input | 8 | Received lane-number field |
| tx_valid_o | output | 1 | Transmit request valid |
| tx_ready_i | input | 1 | Transmitter accepts the request |
| tx_type_o | output | 2 | Kind of set to transmit |
| tx_link_o | output | 8 | Link field to transmit |
| tx_lane_o | output | 8 | Lane field to transmit |
| link_up_o | output | 1 | Training complete, link in L0 |

## Verification
The hardest cases to reach are those where the receive condition and the transmit condition finish at different times. Examples are a consecutive run broken midway while the transmit count, started at an earlier set, keeps growing, or a receive target met well before the transmit target. Directed sequences of background sets, partial runs, breaking sets and full runs are timed so that a receive count that does not clear, or a transmit count that starts at the wrong moment, moves the phase change to a different cycle. The first polling phase uses random ready stalls and random TS1/TS2 mixes, and the bench checks that the number of handshakes it counted lands on the threshold. A timeout taken partway through polling then shows that the transmit count restarts from zero.

// File: rtl/lts_pkg.sv
package lts_pkg;
  typedef enum logic [1:0] {
    OS_TS1   = 2'd0,
    OS_TS2   = 2'd1,
    OS_IDLE  = 2'd2,
    OS_OTHER = 2'd3
  } os_kind_e;

  typedef enum logic [3:0] {
    ST_DETECT   = 4'd0,
    ST_POLL_ACT = 4'd1,
    ST_POLL_CFG = 4'd2,
    ST_CFG_LINK = 4'd3,
    ST_CFG_LANE = 4'd4,
    ST_CFG_ACPT = 4'd5,
    ST_CFG_DONE = 4'd6,
    ST_IDLE_HS  = 4'd7,
    ST_L0       = 4'd8
  } trn_state_e;
endpackage

// File: rtl/lts_sat_cnt.sv
module lts_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
  end

  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '1 && !clr_i) |=> (cnt_o == '1));
endmodule

// File: rtl/lts_phase_qual.sv
module lts_phase_qual
  import lts_pkg::*;
#(
  parameter logic [7:0] PAD         = 8'hF7,
  parameter logic [7:0] LOCAL_LANE  = 8'h00,
  parameter int         POLL_TX_MIN = 1024,
  parameter int         RUN_LONG    = 8,
  parameter int         RUN_SHORT   = 2,
  parameter int         TX_TAIL     = 16,
  parameter int         RXW         = 4,
  parameter int         TXW         = 11
) (
  input  trn_state_e     state_i,
  input  os_kind_e       rx_kind_i,
  input  logic [7:0]     rx_link_i,
  input  logic [7:0]     rx_lane_i,
  input  logic [7:0]     cap_link_i,
  input  logic [7:0]     cap_lane_i,
  output logic           hit_o,
  output logic           brk_o,
  output logic           tx_free_o,
  output logic           arm_on_hit_o,
  output logic           cap_link_en_o,
  output logic           cap_lane_en_o,
  output logic [RXW-1:0] rx_need_o,
  output logic [TXW-1:0] tx_need_o,
  output logic           tx_vld_o,
  output os_kind_e       tx_kind_o,
  output logic [7:0]     tx_link_o,
  output logic [7:0]     tx_lane_o
);
  logic link_ok, lane_ok, link_match, lane_match;
  assign link_ok    = (rx_link_i != PAD);
  assign lane_ok    = (rx_lane_i != PAD);
  assign link_match = (rx_link_i == cap_link_i) && link_ok;
  assign lane_match = (rx_lane_i == cap_lane_i) && lane_ok;

  always_comb begin
    hit_o         = 1'b0;
    brk_o         = 1'b0;
    tx_free_o     = 1'b0;
    arm_on_hit_o  = 1'b0;
    cap_link_en_o = 1'b0;
    cap_lane_en_o = 1'b0;
    rx_need_o     = RXW'(RUN_LONG);
    tx_need_o     = '0;
    tx_vld_o      = 1'b1;
    tx_kind_o     = OS_IDLE;
    tx_link_o     = PAD;
    tx_lane_o     = PAD;
    unique case (state_i)
      ST_DETECT: tx_vld_o = 1'b0;
      ST_POLL_ACT: begin
        hit_o     = (rx_kind_i == OS_TS1) || (rx_kind_i == OS_TS2);
        tx_free_o = 1'b1;
        tx_need_o = TXW'(POLL_TX_MIN);
        tx_kind_o = OS_TS1;
      end
      ST_POLL_CFG: begin
        hit_o        = (rx_kind_i == OS_TS2);
        brk_o        = !hit_o;
        arm_on_hit_o = 1'b1;
        tx_need_o    = TXW'(TX_TAIL);
        tx_kind_o    = OS_TS2;
      end
      ST_CFG_LINK: begin
        hit_o         = (rx_kind_i == OS_TS1) && link_ok;
        brk_o         = !hit_o;
        cap_link_en_o = 1'b1;
        rx_need_o     = RXW'(RUN_SHORT);
        tx_kind_o     = OS_TS1;
      end
      ST_CFG_LANE: begin
        hit_o     = (rx_kind_i == OS_TS1) && link_match && lane_ok;
        brk_o     = !hit_o;
        rx_need_o = RXW'(RUN_SHORT);
        tx_kind_o = OS_TS1;
        tx_link_o = cap_link_i;
      end
      ST_CFG_ACPT: begin
        hit_o         = (rx_kind_i == OS_TS2) && link_match && lane_ok;
        brk_o         = !hit_o;
        cap_lane_en_o = 1'b1;
        rx_need_o     = RXW'(RUN_SHORT);
        tx_kind_o     = OS_TS1;
        tx_link_o     = cap_link_i;
        tx_lane_o     = LOCAL_LANE;
      end
      ST_CFG_DONE: begin
        hit_o        = (rx_kind_i == OS_TS2) && link_match && lane_match;
        brk_o        = !hit_o;
        arm_on_hit_o = 1'b1;
        tx_need_o    = TXW'(TX_TAIL);
        tx_kind_o    = OS_TS2;
        tx_link_o    = cap_link_i;
        tx_lane_o    = cap_lane_i;
      end
      ST_IDLE_HS, ST_L0: begin
        hit_o        = (rx_kind_i == OS_IDLE);
        brk_o        = !hit_o;
        arm_on_hit_o = 1'b1;
        tx_need_o    = TXW'(TX_TAIL);
      end
      default: tx_vld_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lts_seq.sv
module lts_seq
  import lts_pkg::*;
#(
  parameter logic [7:0] PAD         = 8'hF7,
  parameter logic [7:0] LOCAL_LANE  = 8'h00,
  parameter int         POLL_TX_MIN = 1024,
  parameter int         RUN_LONG    = 8,
  parameter int         RUN_SHORT   = 2,
  parameter int         TX_TAIL     = 16,
  parameter int         TMO_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_detected_i,
  input  logic [TMO_W-1:0] timeout_lim_i,
  input  logic             rx_valid_i,
  input  logic [1:0]       rx_type_i,
  input  logic [7:0]       rx_link_i,
  input  logic [7:0]       rx_lane_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [1:0]       tx_type_o,
  output logic [7:0]       tx_link_o,
  output logic [7:0]       tx_lane_o,
  output logic             link_up_o
);
  localparam int RXW    = $clog2(RUN_LONG + 1);
  localparam int TX_MAX = (POLL_TX_MIN > TX_TAIL) ? POLL_TX_MIN : TX_TAIL;
  localparam int TXW    = $clog2(TX_MAX + 1);

  trn_state_e     state, state_d;
  logic [7:0]     cap_link, cap_lane;
  logic           armed;
  logic [RXW-1:0] rx_cnt, rx_need;
  logic [TXW-1:0] tx_cnt, tx_need;
  logic [TMO_W-1:0] tmr;
  logic hit, brk, tx_free, arm_on_hit, cap_link_en, cap_lane_en;
  logic rx_ev, rx_met, tx_met, tx_fire, training, tmo, adv, phase_clr;
  os_kind_e tx_kind;

  lts_phase_qual #(
    .PAD(PAD), .LOCAL_LANE(LOCAL_LANE), .POLL_TX_MIN(POLL_TX_MIN),
    .RUN_LONG(RUN_LONG), .RUN_SHORT(RUN_SHORT), .TX_TAIL(TX_TAIL),
    .RXW(RXW), .TXW(TXW)
  ) u_qual (
    .state_i(state), .rx_kind_i(os_kind_e'(rx_type_i)),
    .rx_link_i(rx_link_i), .rx_lane_i(rx_lane_i),
    .cap_link_i(cap_link), .cap_lane_i(cap_lane),
    .hit_o(hit), .brk_o(brk), .tx_free_o(tx_free), .arm_on_hit_o(arm_on_hit),
    .cap_link_en_o(cap_link_en), .cap_lane_en_o(cap_lane_en),
    .rx_need_o(rx_need), .tx_need_o(tx_need),
    .tx_vld_o(tx_valid_o), .tx_kind_o(tx_kind),
    .tx_link_o(tx_link_o), .tx_lane_o(tx_lane_o)
  );

  assign tx_type_o = tx_kind;
  assign link_up_o = (state == ST_L0);

  assign training  = (state != ST_DETECT) && (state != ST_L0);
  assign rx_ev     = rx_valid_i && hit;
  assign rx_met    = (rx_cnt >= rx_need);
  assign tx_met    = (tx_cnt >= tx_need);
  assign tx_fire   = tx_valid_o && tx_ready_i;
  assign tmo       = training && (timeout_lim_i != '0) && (tmr >= timeout_lim_i);
  assign adv       = training && rx_met && tx_met && !tmo;
  assign phase_clr = tmo || adv || (state == ST_DETECT);

  // run target, once reached, is not undone by later breaking sets
  lts_sat_cnt #(.W(RXW)) u_rx_cnt (
    .clk_i, .rst_ni,
    .clr_i(phase_clr || (rx_valid_i && brk && !rx_met)),
    .inc_i(rx_ev), .cnt_o(rx_cnt)
  );

  lts_sat_cnt #(.W(TXW)) u_tx_cnt (
    .clk_i, .rst_ni, .clr_i(phase_clr),
    .inc_i(tx_fire && (tx_free || armed || (arm_on_hit && rx_ev))),
    .cnt_o(tx_cnt)
  );

  lts_sat_cnt #(.W(TMO_W)) u_tmr (
    .clk_i, .rst_ni, .clr_i(!training || adv || tmo),
    .inc_i(training), .cnt_o(tmr)
  );

  always_comb begin
    state_d = state;
    if (state == ST_DETECT) begin
      if (rx_detected_i) state_d = ST_POLL_ACT;
    end else if (tmo) begin
      state_d = ST_DETECT;
    end else if (adv) begin
      unique case (state)
        ST_POLL_ACT: state_d = ST_POLL_CFG;
        ST_POLL_CFG: state_d = ST_CFG_LINK;
        ST_CFG_LINK: state_d = ST_CFG_LANE;
        ST_CFG_LANE: state_d = ST_CFG_ACPT;
        ST_CFG_ACPT: state_d = ST_CFG_DONE;
        ST_CFG_DONE: state_d = ST_IDLE_HS;
        ST_IDLE_HS:  state_d = ST_L0;
        default:     state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_DETECT;
      cap_link <= PAD;
      cap_lane <= PAD;
      armed    <= 1'b0;
    end else begin
      state <= state_d;
      if (phase_clr)                    armed <= 1'b0;
      else if (arm_on_hit && rx_ev)     armed <= 1'b1;
      if (tmo || state == ST_DETECT) begin
        cap_link <= PAD;
        cap_lane <= PAD;
      end else begin
        if (cap_link_en && rx_ev) cap_link <= rx_link_i;
        if (cap_lane_en && rx_ev) cap_lane <= rx_lane_i;
      end
    end
  end

  assert_up_sends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |-> tx_valid_o);
  assert_poll_tx_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_POLL_CFG && $past(state) == ST_POLL_ACT) |-> ($past(tx_cnt) >= TXW'(POLL_TX_MIN)));
  assert_poll_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_CFG_LINK && $past(state) == ST_POLL_CFG) |-> ($past(rx_cnt) >= RXW'(RUN_LONG)));
  assert_up_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |=> link_up_o);
  assert_timeout_detect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |=> (state == ST_DETECT && !tx_valid_o));
  assert_rx_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_i && !adv && !tmo) |=> $stable(rx_cnt));
  assert_tx_handshake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_fire && !adv && !tmo && state != ST_DETECT) |=> $stable(tx_cnt));
endmodule

// File: tb/lts_seq_tb.sv
module lts_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PAD = 8'hF7;
  localparam logic [1:0] K_TS1 = 2'd0, K_TS2 = 2'd1, K_IDL = 2'd2, K_OTH = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_detected = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
  logic [15:0] tmo_lim = '0;
  logic [1:0] rx_type = K_OTH;
  logic [7:0] rx_link = PAD, rx_lane = PAD;
  logic tx_valid, link_up;
  logic [1:0] tx_type;
  logic [7:0] tx_link, tx_lane;
  int n_chk = 0, n_fail = 0, hs = 0;
  int unsigned seed_v = 32'h5EED;

  always #(CLK_PERIOD/2) clk = ~clk;

  lts_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_detected_i(rx_detected), .timeout_lim_i(tmo_lim),
    .rx_valid_i(rx_valid), .rx_type_i(rx_type), .rx_link_i(rx_link), .rx_lane_i(rx_lane),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_type_o(tx_type),
    .tx_link_o(tx_link), .tx_lane_o(tx_lane), .link_up_o(link_up)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_is(input string req, input logic [1:0] k, input logic [7:0] lk, input logic [7:0] ln);
    chk(tx_valid && tx_type == k && tx_link == lk && tx_lane == ln, req,
        {tx_valid, 6'd0, tx_type, tx_link, tx_lane}, {1'b1, 6'd0, k, lk, ln});
  endtask

  // called at negedge; one ordered set for one cycle
  task automatic step(input logic [1:0] t, input logic [7:0] lk, input logic [7:0] ln,
                      input logic v, input logic rdy);
    rx_type = t; rx_link = lk; rx_lane = ln; rx_valid = v; tx_ready = rdy;
    if (tx_valid && rdy) hs++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n, input logic [1:0] t, input logic [7:0] lk, input logic [7:0] ln);
    for (int i = 0; i < n; i++) step(t, lk, ln, 1'b1, 1'b1);
  endtask

  function automatic bit in_window(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  initial begin
    void'($urandom(seed_v));
    repeat (3) @(negedge clk);
    chk(!tx_valid && !link_up, "R1 reset state", {tx_valid, link_up}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: random traffic without a receiver, block stays silent
    for (int i = 0; i < 10; i++) begin
      step(2'($urandom), 8'($urandom), 8'($urandom), 1'b1, 1'b1);
      chk(!tx_valid && !link_up, "R1 detect quiet", {tx_valid, link_up}, 0);
    end
    rx_detected = 1'b1;
    step(K_OTH, PAD, PAD, 1'b1, 1'b1);
    tx_is("R2 R11 polling TS1 with PAD", K_TS1, PAD, PAD);

    // R2 R10: random stalls, random TS1/TS2 mix
    hs = 0;
    for (int i = 0; i < 4000; i++) begin
      if (i < 20) step(K_OTH, PAD, PAD, 1'b1, ($urandom % 4) != 0);
      else step(1'($urandom), PAD, PAD, ($urandom % 3) != 0, ($urandom % 4) != 0);
      if (tx_type != K_TS1) break;
    end
    chk(in_window(hs, 1024, 1025), "R2 R10 polling exit handshake count", hs, 1024);
    tx_is("R3 second polling TS2", K_TS2, PAD, PAD);

    // R3: background, partial run, break, full run
    steps(5, K_OTH, PAD, PAD);
    steps(7, K_TS2, PAD, PAD);
    steps(10, K_TS1, PAD, PAD);
    steps(7, K_TS2, PAD, PAD);
    tx_is("R3 broken run not enough", K_TS2, PAD, PAD);
    steps(1, K_TS2, PAD, PAD);
    tx_is("R3 phase change one cycle after targets", K_TS2, PAD, PAD);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R4 config starts PAD/PAD", K_TS1, PAD, PAD);

    // R4 R10: PAD link, unstrobed sets, wrong kind do not count
    steps(3, K_TS1, PAD, PAD);
    for (int i = 0; i < 3; i++) step(K_TS1, 8'h2A, PAD, 1'b0, 1'b1);
    steps(1, K_TS2, 8'h2A, PAD);
    tx_is("R4 R10 ignored sets", K_TS1, PAD, PAD);
    steps(2, K_TS1, 8'h2A, PAD);
    tx_is("R4 two valid links registered", K_TS1, PAD, PAD);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R5 link echoed", K_TS1, 8'h2A, PAD);

    // R5
    steps(3, K_TS1, 8'h2A, PAD);
    tx_is("R5 PAD lane ignored", K_TS1, 8'h2A, PAD);
    steps(2, K_TS1, 8'h2A, 8'h03);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R6 own lane sent", K_TS1, 8'h2A, 8'h00);

    // R6
    steps(3, K_TS2, 8'h11, 8'h03);
    tx_is("R6 mismatched link ignored", K_TS1, 8'h2A, 8'h00);
    steps(2, K_TS2, 8'h2A, 8'h03);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R7 received link and lane used", K_TS2, 8'h2A, 8'h03);

    // R7: tx count starts at first matching TS2
    steps(4, K_OTH, PAD, PAD);
    steps(5, K_TS2, 8'h2A, 8'h03);
    steps(1, K_TS2, 8'h2A, 8'h04);
    steps(8, K_TS2, 8'h2A, 8'h03);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R7 fifteen sent not enough", K_TS2, 8'h2A, 8'h03);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R7 sixteenth just registered", K_TS2, 8'h2A, 8'h03);
    steps(1, K_OTH, PAD, PAD);
    tx_is("R8 idle phase", K_IDL, PAD, PAD);

    // R8
    steps(3, K_TS2, 8'h2A, 8'h03);
    steps(4, K_IDL, PAD, PAD);
    steps(1, K_TS1, PAD, PAD);
    steps(8, K_IDL, PAD, PAD);
    steps(3, K_OTH, PAD, PAD);
    chk(!link_up, "R8 link not up at threshold", link_up, 0);
    steps(1, K_OTH, PAD, PAD);
    chk(link_up, "R8 link up", link_up, 1);
    for (int i = 0; i < 5; i++) step(2'($urandom), 8'($urandom), 8'($urandom), 1'b1, 1'($urandom));
    tx_is("R8 idle kept in L0", K_IDL, PAD, PAD);
    chk(link_up, "R8 link stays up", link_up, 1);

    // R9: timeout mid-polling, counts restart
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !link_up, "R1 reset again", {tx_valid, link_up}, 0);
    rst_ni = 1'b1;
    tmo_lim = 16'd2000;
    step(K_OTH, PAD, PAD, 1'b1, 1'b1);
    rx_detected = 1'b0;
    steps(600, K_TS1, PAD, PAD);
    tx_is("R9 no early timeout", K_TS1, PAD, PAD);
    tmo_lim = 16'd100;
    steps(2, K_TS1, PAD, PAD);
    chk(!tx_valid, "R9 back to detect", tx_valid, 0);
    tmo_lim = '0;
    rx_detected = 1'b1;
    hs = 0;
    for (int i = 0; i < 3000; i++) begin
      step(K_TS1, PAD, PAD, 1'b1, 1'b1);
      if (tx_valid && tx_type != K_TS1) break;
    end
    chk(in_window(hs, 1024, 1025), "R9 tx count cleared by timeout", hs, 1024);
    summary();
  end
endmodule